// File: doc/BRIEF.md
# Buffered SPI Master Controller

This block is a register-mapped serial peripheral interface master. Software writes words of 1 to 16 bits into a transmit queue through a small register bus. The controller shifts each word out on MOSI, and for every word sent it captures a word of the same length from MISO, or from its own MOSI when loopback is on. Captured words go into a receive queue, which software drains by reading the receive register. Both queues hold eight words. An interrupt can be raised once the transmit queue and the shifter have both run dry. Chip select lives outside the block.

The serial clock comes from a half-period divider. Polarity, phase, bit order and word length are set in the control register. Transfers start on their own once the controller is enabled in master mode and at least one word is queued. Queued words go out back to back with no idle time between them.

The shifter is a three-state machine. ENG_IDLE goes to ENG_LEAD when the controller is enabled, master mode is set and a word is queued; that word is popped on the same edge. ENG_LEAD goes to ENG_TRAIL after one half period, and the receive bit is sampled on that edge. ENG_TRAIL goes back to ENG_LEAD after one half period if bits of the word remain. At the last bit of a word, ENG_TRAIL pushes the received word and then goes to ENG_LEAD if another word can be loaded, or to ENG_IDLE if not. A soft reset sends every state to ENG_IDLE.

Top module: `spi_fifo_master`

## Requirements
- R1: Registers sit at word index 0 (divider, bits 15:0), 1 (transmit write), 2 (receive read), 3 (control, bits 12:0) and 4 (interrupt enable in bit 2, sticky receive-overflow flag in bit 3). Divider, control and interrupt-enable read back what was last written. After reset all three are zero, irq is 0 and sclk is 0.
- R2: Each half of a bit period lasts D clock cycles, where D is the divider value. A divider value of 0 gives 65536 cycles.
- R3: Control bits 3:0 hold the word length minus one. Each received word is stored right-aligned in that many bits, with the upper bits zero.
- R4: Control bit 4 set sends and receives most significant bit first. Clear sends least significant bit first.
- R5: Control bit 6 is the idle level of sclk, and sclk returns to it after a burst. With control bit 5 clear, data is sampled on the first edge of each bit. With bit 5 set, data is sampled on the second edge.
- R6: Control bit 10 set feeds MOSI back into the receiver. Clear, the receiver takes MISO.
- R7: Shifting starts only when control bits 9 (enable) and 8 (master) are both set and the transmit queue holds a word.
- R8: The transmit queue holds 8 words. A write while it is full is dropped.
- R9: The receive queue holds 8 words. A word completed while it is full is dropped and sets the sticky overflow flag.
- R10: A receive read while the receive queue is empty returns the last popped word and leaves the queue unchanged.
- R11: irq is high exactly when interrupt-enable bit 2 is set, the transmit queue is empty and the shifter is idle.
- R12: While control bit 7 is high, both queues are emptied, the shifter is returned to idle and the overflow flag is cleared. The last popped word is kept.
- R13: With control bit 11 clear the transmit queue accepts only one word. With control bit 12 clear the receive queue keeps only one word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops receive queue at index 2) |
| bus_addr | input | 3 | Register word index |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| miso | input | 1 | Serial data in |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| irq | output | 1 | Transmit-drained interrupt |

## Verification
The assertions assume that the divider, word length, bit order and phase fields stay fixed while the shifter is busy. Bit-index and half-period-counter bounds, and MOSI holding across the sampling edge, are only guaranteed under that condition. The stimulus rewrites these fields only while the controller is disabled, after waiting for irq to show the shifter idle. Only the enable bit is set while words are pending. Soft reset is the one control change applied in the middle of a transfer, and it returns the shifter to idle.

// File: rtl/spi_fifo_pkg.sv
package spi_fifo_pkg;
    localparam int DATA_W     = 16;
    localparam int FIFO_DEPTH = 8;
    localparam int BRG_W      = 16;
    localparam int LEN_W      = 4;
    localparam int CTL_W      = 13;
    localparam int ADDR_W     = 3;

    localparam logic [ADDR_W-1:0] REG_BRG = 3'd0;
    localparam logic [ADDR_W-1:0] REG_TXB = 3'd1;
    localparam logic [ADDR_W-1:0] REG_RXB = 3'd2;
    localparam logic [ADDR_W-1:0] REG_CTL = 3'd3;
    localparam logic [ADDR_W-1:0] REG_IEN = 3'd4;

    localparam int CB_MSB  = 4;
    localparam int CB_CPHA = 5;
    localparam int CB_CPOL = 6;
    localparam int CB_SRST = 7;
    localparam int CB_MST  = 8;
    localparam int CB_EN   = 9;
    localparam int CB_LOOP = 10;
    localparam int CB_TXF  = 11;
    localparam int CB_RXF  = 12;

    localparam int IB_TXE = 2;
    localparam int IB_OVF = 3;

    typedef enum logic [1:0] {
        ENG_IDLE  = 2'd0,
        ENG_LEAD  = 2'd1,
        ENG_TRAIL = 2'd2
    } eng_state_t;
endpackage

// File: rtl/spi_word_fifo.sv
module spi_word_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         single,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         empty,
    output logic         full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count;
    logic          do_push, do_pop;

    function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign empty   = (count == '0);
    assign full    = single ? (count != '0) : (count == CW'(DEPTH));
    assign do_push = push && !full && !clr;
    assign do_pop  = pop && !empty && !clr;
    assign head    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else if (clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= ptr_next(wr_ptr);
            if (do_pop)  rd_ptr <= ptr_next(rd_ptr);
            if (do_push && !do_pop)      count <= count + 1'b1;
            else if (do_pop && !do_push) count <= count - 1'b1;
        end
    end

    // R8
    full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop && !clr) |=> (count == $past(count)));

    // R8
    depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
    import spi_fifo_pkg::*;
#(
    parameter int W     = DATA_W,
    parameter int LW    = LEN_W,
    parameter int HALFW = BRG_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             go,
    input  logic [LW-1:0]    len_m1,
    input  logic             msb_first,
    input  logic             cpha,
    input  logic             cpol,
    input  logic             loopback,
    input  logic [HALFW-1:0] half,
    input  logic             tx_avail,
    input  logic [W-1:0]     tx_word,
    output logic             tx_pop,
    input  logic             miso,
    output logic             rx_push,
    output logic [W-1:0]     rx_word,
    output logic             sclk,
    output logic             mosi,
    output logic             busy
);
    eng_state_t       st_q, st_d;
    logic [HALFW-1:0] cnt_q, cnt_d, half_m1;
    logic [LW-1:0]    idx_q, idx_d, bit_sel;
    logic [W-1:0]     txw_q, txw_d, rxw_q, rxw_d;
    logic             rx_bit, last_bit;

    assign half_m1  = half - 1'b1;
    assign rx_bit   = loopback ? mosi : miso;
    assign last_bit = (idx_q == len_m1);
    assign bit_sel  = msb_first ? (len_m1 - idx_q) : idx_q;

    always_comb begin
        st_d    = st_q;
        cnt_d   = cnt_q;
        idx_d   = idx_q;
        txw_d   = txw_q;
        rxw_d   = rxw_q;
        tx_pop  = 1'b0;
        rx_push = 1'b0;
        unique case (st_q)
            ENG_IDLE: begin
                if (go && tx_avail) begin
                    tx_pop = 1'b1;
                    txw_d  = tx_word;
                    idx_d  = '0;
                    rxw_d  = '0;
                    cnt_d  = half_m1;
                    st_d   = ENG_LEAD;
                end
            end
            ENG_LEAD: begin
                if (cnt_q == '0) begin
                    if (msb_first) rxw_d = {rxw_q[W-2:0], rx_bit};
                    else           rxw_d[idx_q] = rx_bit;
                    cnt_d = half_m1;
                    st_d  = ENG_TRAIL;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            ENG_TRAIL: begin
                if (cnt_q == '0) begin
                    if (last_bit) begin
                        rx_push = 1'b1;
                        if (go && tx_avail) begin
                            tx_pop = 1'b1;
                            txw_d  = tx_word;
                            idx_d  = '0;
                            rxw_d  = '0;
                            cnt_d  = half_m1;
                            st_d   = ENG_LEAD;
                        end else begin
                            st_d = ENG_IDLE;
                        end
                    end else begin
                        idx_d = idx_q + 1'b1;
                        cnt_d = half_m1;
                        st_d  = ENG_LEAD;
                    end
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            default: st_d = ENG_IDLE;
        endcase
        if (clr) begin
            st_d    = ENG_IDLE;
            tx_pop  = 1'b0;
            rx_push = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ENG_IDLE;
            cnt_q <= '0;
            idx_q <= '0;
            txw_q <= '0;
            rxw_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
            idx_q <= idx_d;
            txw_q <= txw_d;
            rxw_q <= rxw_d;
        end
    end

    always_comb begin
        busy    = (st_q != ENG_IDLE);
        rx_word = rxw_q;
        unique case (st_q)
            ENG_LEAD:  sclk = cpol ^ cpha;
            ENG_TRAIL: sclk = cpol ^ ~cpha;
            default:   sclk = cpol;
        endcase
        mosi = busy ? txw_q[bit_sel] : 1'b0;
    end

    // R3
    idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != ENG_IDLE) |-> (idx_q <= len_m1));

    // R2
    half_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != ENG_IDLE) |-> (cnt_q <= half_m1));

    // R5
    mosi_sample_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ENG_TRAIL && $past(st_q) == ENG_LEAD) |-> $stable(mosi));
endmodule

// File: rtl/spi_fifo_master.sv
module spi_fifo_master
    import spi_fifo_pkg::*;
#(
    parameter int W     = DATA_W,
    parameter int DEPTH = FIFO_DEPTH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [15:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              miso,
    output logic              sclk,
    output logic              mosi,
    output logic              irq
);
    localparam int HALFW = BRG_W + 1;

    logic [BRG_W-1:0] brg_q;
    logic [CTL_W-1:0] ctl_q;
    logic             ien_q, ovf_q;
    logic [W-1:0]     last_rx_q;

    logic             srst, go;
    logic [HALFW-1:0] half;
    logic             tx_push, tx_pop, tx_empty, tx_full;
    logic [W-1:0]     tx_head;
    logic             rx_push, rx_pop, rx_empty, rx_full;
    logic [W-1:0]     rx_head, rx_word;
    logic             busy;

    assign srst    = ctl_q[CB_SRST];
    assign go      = ctl_q[CB_EN] && ctl_q[CB_MST] && !srst;
    assign half    = (brg_q == '0) ? HALFW'(1 << BRG_W) : {1'b0, brg_q};
    assign tx_push = bus_wr && (bus_addr == REG_TXB);
    assign rx_pop  = bus_rd && (bus_addr == REG_RXB);

    spi_word_fifo #(.W(W), .DEPTH(DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .clr(srst), .single(!ctl_q[CB_TXF]),
        .push(tx_push), .wdata(bus_wdata[W-1:0]), .pop(tx_pop),
        .head(tx_head), .empty(tx_empty), .full(tx_full)
    );

    spi_word_fifo #(.W(W), .DEPTH(DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .clr(srst), .single(!ctl_q[CB_RXF]),
        .push(rx_push), .wdata(rx_word), .pop(rx_pop),
        .head(rx_head), .empty(rx_empty), .full(rx_full)
    );

    spi_shift_engine #(.W(W), .LW(LEN_W), .HALFW(HALFW)) u_eng (
        .clk(clk), .rst_n(rst_n), .clr(srst), .go(go),
        .len_m1(ctl_q[LEN_W-1:0]), .msb_first(ctl_q[CB_MSB]),
        .cpha(ctl_q[CB_CPHA]), .cpol(ctl_q[CB_CPOL]),
        .loopback(ctl_q[CB_LOOP]), .half(half),
        .tx_avail(!tx_empty), .tx_word(tx_head), .tx_pop(tx_pop),
        .miso(miso), .rx_push(rx_push), .rx_word(rx_word),
        .sclk(sclk), .mosi(mosi), .busy(busy)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            brg_q     <= '0;
            ctl_q     <= '0;
            ien_q     <= 1'b0;
            ovf_q     <= 1'b0;
            last_rx_q <= '0;
        end else begin
            if (bus_wr && bus_addr == REG_BRG) brg_q <= bus_wdata[BRG_W-1:0];
            if (bus_wr && bus_addr == REG_CTL) ctl_q <= bus_wdata[CTL_W-1:0];
            if (bus_wr && bus_addr == REG_IEN) ien_q <= bus_wdata[IB_TXE];
            if (srst)                          ovf_q <= 1'b0;
            else if (rx_push && rx_full)       ovf_q <= 1'b1;
            if (rx_pop && !rx_empty && !srst)  last_rx_q <= rx_head;
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            REG_BRG: bus_rdata[BRG_W-1:0] = brg_q;
            REG_RXB: bus_rdata[W-1:0]     = rx_empty ? last_rx_q : rx_head;
            REG_CTL: bus_rdata[CTL_W-1:0] = ctl_q;
            REG_IEN: begin
                bus_rdata[IB_TXE] = ien_q;
                bus_rdata[IB_OVF] = ovf_q;
            end
            default: bus_rdata = '0;
        endcase
    end

    assign irq = ien_q && tx_empty && !busy;

    // R9
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_q && !srst) |=> ovf_q);

    // R12
    srst_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        srst |=> (tx_empty && rx_empty && !busy));

    // R7
    no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!go && !busy) |=> !busy);
endmodule

// File: tb/spi_fifo_master_test.sv
module spi_fifo_master_test;
    localparam int WD = 190000;
    localparam logic [2:0] A_BRG = 3'd0, A_TXB = 3'd1, A_RXB = 3'd2, A_CTL = 3'd3, A_IEN = 3'd4;
    localparam int B_MSB = 16, B_CPHA = 32, B_CPOL = 64, B_SRST = 128, B_MST = 256,
                   B_EN = 512, B_LOOP = 1024, B_TXF = 2048, B_RXF = 4096;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        miso, sclk, mosi, irq;

    int total = 0, bad = 0, cyc = 0, cap_n = 0;
    bit m_cpha = 0, m_cpol = 0, done = 0;
    logic prev_sclk = 1'b0;
    bit cap_bits [256];

    assign miso = ~mosi;

    spi_fifo_master uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .miso(miso), .sclk(sclk), .mosi(mosi), .irq(irq)
    );

    always #5 clk = ~clk;

    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (sclk !== prev_sclk) begin
            if (sclk == (m_cpol ^ !m_cpha) && cap_n < 256) begin
                cap_bits[cap_n] = mosi;
                cap_n = cap_n + 1;
            end
        end
        prev_sclk = sclk;
    end

    always @(negedge clk) begin
        if (!done && cyc >= WD) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=%0d expected<%0d", cyc, WD);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk); bus_rd = (a == A_RXB); bus_addr = a; #1 d = bus_rdata;
        @(negedge clk); bus_rd = 1'b0;
    endtask

    task automatic cfg(input int v);
        m_cpha = (v & B_CPHA) != 0;
        m_cpol = (v & B_CPOL) != 0;
        wr(A_CTL, 16'(v));
        @(negedge clk); #2 cap_n = 0;
    endtask

    task automatic wait_irq(input string req);
        int n = 0;
        repeat (3) @(negedge clk);
        while (irq !== 1'b1 && n < 20000) begin @(negedge clk); n++; end
        if (n >= 20000) chk(1'b0, req, 0, 1);
    endtask

    task automatic measure_half(output int h);
        int n = 0;
        h = 0;
        while (sclk == m_cpol && n < 200) begin @(negedge clk); n++; end
        if (sclk != m_cpol) begin
            h = 1;
            forever begin
                @(negedge clk);
                if (sclk != m_cpol && h < 70000) h++; else break;
            end
        end
    endtask

    function automatic logic [15:0] lmask(input int len);
        return (len >= 16) ? 16'hFFFF : 16'((1 << len) - 1);
    endfunction

    function automatic logic [31:0] exp_rx(input logic [15:0] w, input int len, input bit loop);
        return {16'h0, (loop ? w : ~w) & lmask(len)};
    endfunction

    task automatic run_trial(input int len, input bit msb, input bit cpha, input bit cpol,
                             input bit loop, input int brg, input int n);
        logic [15:0] w [8];
        logic [31:0] r;
        int base, miss;
        base = (len - 1) | (msb ? B_MSB : 0) | (cpha ? B_CPHA : 0) | (cpol ? B_CPOL : 0)
             | B_MST | (loop ? B_LOOP : 0) | B_TXF | B_RXF;
        wr(A_BRG, 16'(brg));
        cfg(base);
        for (int i = 0; i < n; i++) begin
            w[i] = 16'($urandom);
            wr(A_TXB, w[i]);
        end
        wr(A_CTL, 16'(base | B_EN));
        wait_irq("R7 trial irq");
        chk(sclk == cpol, "R5 sclk idle level", 32'(sclk), 32'(cpol));
        for (int i = 0; i < n; i++) begin
            rd(A_RXB, r);
            chk(r == exp_rx(w[i], len, loop), "R3 R6 received word", r, exp_rx(w[i], len, loop));
        end
        chk(cap_n == n * len, "R3 bit count on wire", 32'(cap_n), 32'(n * len));
        miss = 0;
        for (int i = 0; i < n; i++)
            for (int j = 0; j < len; j++)
                if (i * len + j < cap_n)
                    if (cap_bits[i * len + j] != (msb ? w[i][len - 1 - j] : w[i][j])) miss++;
        chk(miss == 0, "R4 R5 serial bit order", 32'(miss), 0);
        cfg(base);
    endtask

    initial begin
        logic [31:0] r;
        int h, seed, base;
        seed = $urandom(32'h5eed_0042);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset values
        rd(A_BRG, r); chk(r == 0, "R1 divider reset", r, 0);
        rd(A_CTL, r); chk(r == 0, "R1 control reset", r, 0);
        rd(A_IEN, r); chk(r == 0, "R1 ien reset", r, 0);
        chk(irq == 0 && sclk == 0, "R1 irq sclk reset", {irq, sclk}, 0);
        wr(A_BRG, 16'h1234); rd(A_BRG, r); chk(r == 32'h1234, "R1 divider readback", r, 32'h1234);
        wr(A_CTL, 16'h1A5F); rd(A_CTL, r); chk(r == 32'h1A5F, "R1 control readback", r, 32'h1A5F);
        cfg(0);

        // R11 irq gating
        chk(irq == 0, "R11 irq low with enable clear", 32'(irq), 0);
        wr(A_IEN, 16'h4); @(negedge clk);
        chk(irq == 1, "R11 irq high when idle and empty", 32'(irq), 1);
        rd(A_IEN, r); chk(r == 4, "R1 ien readback", r, 4);

        // R2 half period
        base = B_CPHA | B_MST | B_LOOP | B_TXF | B_RXF;
        wr(A_BRG, 16'd7); cfg(base);
        wr(A_TXB, 16'h1); wr(A_CTL, 16'(base | B_EN));
        measure_half(h); chk(h == 7, "R2 half period 7", 32'(h), 7);
        wait_irq("R2 irq");
        rd(A_RXB, r);
        wr(A_BRG, 16'd0); cfg(base);
        wr(A_TXB, 16'h1); wr(A_CTL, 16'(base | B_EN));
        @(negedge clk);
        chk(irq == 0, "R11 irq low while shifting", 32'(irq), 0);
        measure_half(h); chk(h == 65536, "R2 divider zero", 32'(h), 65536);
        cfg(base | B_SRST); cfg(base);

        // R7 no master
        base = 7 | B_MSB | B_LOOP | B_TXF | B_RXF;
        wr(A_BRG, 16'd7);
        cfg(base | B_EN);
        wr(A_TXB, 16'hA5); wr(A_TXB, 16'h3C);
        repeat (100) @(negedge clk);
        chk(cap_n == 0 && irq == 0, "R7 no shift without master", 32'(cap_n), 0);
        wr(A_CTL, 16'(base | B_EN | B_MST));
        wait_irq("R7 irq");
        chk(cap_n == 16, "R7 shift after master set", 32'(cap_n), 16);
        rd(A_RXB, r); chk(r == 32'hA5, "R7 first word", r, 32'hA5);
        rd(A_RXB, r); chk(r == 32'h3C, "R7 second word", r, 32'h3C);
        base = base | B_MST;

        // R8 tx full drop, R10 empty read
        cfg(base);
        for (int i = 0; i < 9; i++) wr(A_TXB, 16'(8'h11 * (i + 1)));
        wr(A_CTL, 16'(base | B_EN));
        wait_irq("R8 irq");
        chk(cap_n == 64, "R8 ninth write dropped", 32'(cap_n), 64);
        for (int i = 0; i < 8; i++) begin
            rd(A_RXB, r);
            chk(r == 32'(8'h11 * (i + 1)), "R8 queued word", r, 32'(8'h11 * (i + 1)));
        end
        rd(A_RXB, r); chk(r == 32'h88, "R10 empty read repeats last", r, 32'h88);
        rd(A_IEN, r); chk(r == 4, "R9 no overflow yet", r, 4);

        // R9 rx overflow
        for (int i = 0; i < 8; i++) wr(A_TXB, 16'(i + 1));
        wait_irq("R9 irq a");
        wr(A_TXB, 16'h77); wr(A_TXB, 16'h66);
        wait_irq("R9 irq b");
        rd(A_IEN, r); chk(r == 12, "R9 overflow flag", r, 12);
        for (int i = 0; i < 8; i++) begin
            rd(A_RXB, r);
            chk(r == 32'(i + 1), "R9 kept words", r, 32'(i + 1));
        end
        rd(A_RXB, r); chk(r == 8, "R9 R10 dropped words absent", r, 8);

        // R12 soft reset
        cfg(base);
        wr(A_TXB, 16'h12); wr(A_TXB, 16'h34); wr(A_TXB, 16'h56);
        cfg(base | B_SRST); cfg(base);
        rd(A_IEN, r); chk(r == 4, "R12 overflow cleared", r, 4);
        wr(A_CTL, 16'(base | B_EN));
        repeat (40) @(negedge clk);
        chk(cap_n == 0 && irq == 1, "R12 tx queue flushed", 32'(cap_n), 0);
        rd(A_RXB, r); chk(r == 8, "R12 last popped kept", r, 8);

        // R13 single-entry queues
        cfg(base & ~B_TXF);
        wr(A_TXB, 16'h21); wr(A_TXB, 16'h22); wr(A_TXB, 16'h23);
        wr(A_CTL, 16'((base & ~B_TXF) | B_EN));
        wait_irq("R13 irq tx");
        chk(cap_n == 8, "R13 tx single entry", 32'(cap_n), 8);
        rd(A_RXB, r); chk(r == 32'h21, "R13 tx kept first", r, 32'h21);
        cfg(base & ~B_RXF);
        wr(A_TXB, 16'h31); wr(A_TXB, 16'h32); wr(A_TXB, 16'h33);
        wr(A_CTL, 16'((base & ~B_RXF) | B_EN));
        wait_irq("R13 irq rx");
        rd(A_IEN, r); chk(r == 12, "R13 rx single overflow", r, 12);
        rd(A_RXB, r); chk(r == 32'h31, "R13 rx kept first", r, 32'h31);
        rd(A_RXB, r); chk(r == 32'h31, "R13 rx holds one", r, 32'h31);
        cfg(base | B_SRST); cfg(base);

        // random trials covering R3 R4 R5 R6
        run_trial(16, 1, 1, 1, 0, 7, 8);
        run_trial(1, 0, 0, 0, 1, 8, 3);
        for (int t = 0; t < 14; t++)
            run_trial(1 + int'($urandom % 16), 1'($urandom), 1'($urandom), 1'($urandom),
                      1'(t % 2), 7 + int'($urandom % 4), 1 + int'($urandom % 8));

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule